// File: doc/BRIEF.md
# ADC Output Data Formatter

This block turns each 12-bit result from a converter core into the 14-bit word that goes to the output serializer. The word has twelve data bits and two extension bits. A two-bit range flag from the core drives saturation. Samples beyond positive full scale become the top code, and samples at or beyond negative full scale become the bottom code. The extension pair is raised only for positive over-range. The clamped code then passes through these stages in turn:

- an optional conversion from offset binary to two's complement;
- an optional LSB-keyed XOR scrambler;
- a test-pattern substitution that overrides every other option;
- an output-disable gate.

The result is registered once, so a sample appears one clock after it is presented. Frame and data-clock markers are carried through with the same one-cycle delay. Only the disable gate affects them.

The mode bits and the pattern words are levels that a separate configuration block holds. The formatter samples them together with the data. A pattern change therefore shows on the next sample. A combinational descrambler is included for the receiving side. It recovers the word exactly as it was before scrambling.

Top module: `adc_out_formatter`

## Requirements
- R1: While `rst` is high, and on the first sample edge after it, every output of the registered path (`fmt_data`, `fmt_ext`, `fmt_frame`, `fmt_dclk`) reads zero.
- R2: In offset-binary mode with range flag 00 and no other option enabled, `fmt_data` equals the `core_code` value presented one clock earlier, and `fmt_ext` is 00.
- R3: Range flag 01 (positive over-range) forces the data to the top code, regardless of `core_code`. The top code is 12'hFFF in offset binary and 12'h7FF in two's complement. `fmt_ext` becomes 11.
- R4: Range flag 10 (negative over-range) forces the data to the bottom code. The bottom code is 12'h000 in offset binary and 12'h800 in two's complement. `fmt_ext` stays 00.
- R5: With `mode_twos` set, the output equals the offset-binary code with bit 11 inverted, so mid-scale 12'h800 appears as 12'h000.
- R6: With `mode_scramble` set, bit 0 passes unchanged and each of bits 11..1 is XORed with bit 0. This is applied after the two's-complement step.
- R7: The descrambler maps `rx_data` to `rx_plain` by XORing bit 0 into bits 11..1 when `rx_scramble` is 1, and passes it unchanged when 0. Applied to scrambled output, it returns the unscrambled word.
- R8: With `mode_pattern` set, `fmt_data` becomes {`pat_hi[5:0]`, `pat_lo[5:0]`}, and `fmt_ext` becomes {`pat_hi[7]`, `pat_hi[6]`}. The range flag, two's complement and scrambling have no effect.
- R9: With `mode_off` set, all four registered outputs, including frame and data clock, read zero on the next clock.
- R10: While outputs are enabled, `fmt_frame` and `fmt_dclk` equal `frame_in` and `dclk_in` from one clock earlier, whatever the data mode.
- R11: Range flag 11 is handled as normal: the code passes through and `fmt_ext` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| core_code | input | 12 | Raw offset-binary result from the converter core |
| core_range | input | 2 | Range flag: 00 normal, 01 above full scale, 10 below, 11 normal |
| frame_in | input | 1 | Frame marker to carry through |
| dclk_in | input | 1 | Data-clock marker to carry through |
| mode_twos | input | 1 | Select two's-complement coding |
| mode_scramble | input | 1 | Enable the LSB-keyed XOR scrambler |
| mode_pattern | input | 1 | Substitute the test pattern |
| mode_off | input | 1 | Force all registered outputs low |
| pat_hi | input | 8 | Pattern high word: [7] first extension bit, [6] second, [5:0] data bits 11..6 |
| pat_lo | input | 6 | Pattern low word: data bits 5..0 |
| fmt_data | output | 12 | Formatted data word |
| fmt_ext | output | 2 | Extension pair, {first, second} |
| fmt_frame | output | 1 | Delayed frame marker |
| fmt_dclk | output | 1 | Delayed data-clock marker |
| rx_data | input | 12 | Word to descramble |
| rx_scramble | input | 1 | Descrambler enable |
| rx_plain | output | 12 | Descrambled word |

## Verification
The data path is driven with several input codes:

- Mid-scale and near-mid-scale codes show whether the two's-complement step inverts only the MSB.
- Codes with an odd LSB and with an even LSB show whether the scrambler keys on bit 0 and leaves that bit intact.
- A mid-range code with each of the four range flags separates saturation from pass-through, and shows that the extension pair rises only for positive over-range.

Pattern and disable cases run with scrambling, two's complement and over-range all active, which proves each one overrides the rest. Scrambled outputs are fed back through the descrambler and compared against the unscrambled word.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    localparam int DATA_W  = 12;
    localparam int EXT_W   = 2;
    localparam int HALF_W  = DATA_W / 2;
    localparam int PHI_W   = DATA_W - HALF_W + EXT_W;
    localparam int PLO_W   = HALF_W;

    typedef enum logic [1:0] {
        RANGE_OK   = 2'b00,
        RANGE_HIGH = 2'b01,
        RANGE_LOW  = 2'b10,
        RANGE_ALT  = 2'b11
    } range_e;

    typedef struct packed {
        logic [EXT_W-1:0]  ext;
        logic [DATA_W-1:0] data;
    } word_t;

    typedef struct packed {
        logic twos;
        logic scramble;
        logic pattern;
        logic off;
    } mode_t;

    // XOR bit 0 into every higher bit; self-inverse.
    function automatic logic [DATA_W-1:0] lsb_fold(input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        r = w;
        for (int i = 1; i < DATA_W; i++) begin
            r[i] = w[i] ^ w[0];
        end
        return r;
    endfunction

endpackage

// File: rtl/fmt_clamp.sv
module fmt_clamp
    import adc_fmt_pkg::*;
(
    input  logic [DATA_W-1:0] code,
    input  range_e            rng,
    output word_t             clamped
);
    always_comb begin
        clamped = '0;
        unique case (rng)
            RANGE_HIGH: begin
                clamped.data = '1;
                clamped.ext  = '1;
            end
            RANGE_LOW: begin
                clamped.data = '0;
                clamped.ext  = '0;
            end
            default: begin
                clamped.data = code;
                clamped.ext  = '0;
            end
        endcase
    end
endmodule

// File: rtl/fmt_encode.sv
module fmt_encode
    import adc_fmt_pkg::*;
(
    input  word_t in_word,
    input  logic  twos,
    input  logic  scramble,
    output word_t out_word
);
    word_t coded;

    always_comb begin
        coded = in_word;
        if (twos) begin
            coded.data[DATA_W-1] = ~in_word.data[DATA_W-1];
        end
    end

    always_comb begin
        out_word = coded;
        if (scramble) begin
            out_word.data = lsb_fold(coded.data);
        end
    end
endmodule

// File: rtl/fmt_out_stage.sv
module fmt_out_stage
    import adc_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  word_t            coded,
    input  logic [PHI_W-1:0] pat_hi,
    input  logic [PLO_W-1:0] pat_lo,
    input  mode_t            mode,
    input  logic             frame_in,
    input  logic             dclk_in,
    output word_t            q_word,
    output logic             q_frame,
    output logic             q_dclk
);
    word_t pat_word;
    word_t sel_word;

    always_comb begin
        pat_word.ext  = pat_hi[PHI_W-1 -: EXT_W];
        pat_word.data = {pat_hi[DATA_W-HALF_W-1:0], pat_lo};
        sel_word      = mode.pattern ? pat_word : coded;
    end

    always_ff @(posedge clk) begin
        if (rst || mode.off) begin
            q_word  <= '0;
            q_frame <= 1'b0;
            q_dclk  <= 1'b0;
        end else begin
            q_word  <= sel_word;
            q_frame <= frame_in;
            q_dclk  <= dclk_in;
        end
    end
endmodule

// File: rtl/fmt_unfold.sv
module fmt_unfold
    import adc_fmt_pkg::*;
(
    input  logic [DATA_W-1:0] rx_word,
    input  logic              enable,
    output logic [DATA_W-1:0] plain
);
    genvar g;
    assign plain[0] = rx_word[0];
    generate
        for (g = 1; g < DATA_W; g++) begin : g_bit
            assign plain[g] = enable ? (rx_word[g] ^ rx_word[0]) : rx_word[g];
        end
    endgenerate
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
    import adc_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] core_code,
    input  logic [1:0]        core_range,
    input  logic              frame_in,
    input  logic              dclk_in,
    input  logic              mode_twos,
    input  logic              mode_scramble,
    input  logic              mode_pattern,
    input  logic              mode_off,
    input  logic [PHI_W-1:0]  pat_hi,
    input  logic [PLO_W-1:0]  pat_lo,
    output logic [DATA_W-1:0] fmt_data,
    output logic [EXT_W-1:0]  fmt_ext,
    output logic              fmt_frame,
    output logic              fmt_dclk,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_scramble,
    output logic [DATA_W-1:0] rx_plain
);
    mode_t mode;
    word_t clamped;
    word_t coded;
    word_t q_word;

    assign mode.twos     = mode_twos;
    assign mode.scramble = mode_scramble;
    assign mode.pattern  = mode_pattern;
    assign mode.off      = mode_off;

    fmt_clamp u_clamp (
        .code    (core_code),
        .rng     (range_e'(core_range)),
        .clamped (clamped)
    );

    fmt_encode u_encode (
        .in_word  (clamped),
        .twos     (mode.twos),
        .scramble (mode.scramble),
        .out_word (coded)
    );

    fmt_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .coded    (coded),
        .pat_hi   (pat_hi),
        .pat_lo   (pat_lo),
        .mode     (mode),
        .frame_in (frame_in),
        .dclk_in  (dclk_in),
        .q_word   (q_word),
        .q_frame  (fmt_frame),
        .q_dclk   (fmt_dclk)
    );

    assign fmt_data = q_word.data;
    assign fmt_ext  = q_word.ext;

    fmt_unfold u_unfold (
        .rx_word (rx_data),
        .enable  (rx_scramble),
        .plain   (rx_plain)
    );

    a_r9_off_silences: assert property (@(posedge clk) disable iff (rst)
        mode_off |=> (fmt_data == '0 && fmt_ext == '0 && !fmt_frame && !fmt_dclk));

    a_r8_pattern_wins: assert property (@(posedge clk) disable iff (rst)
        (mode_pattern && !mode_off) |=>
        (fmt_data == {$past(pat_hi[DATA_W-HALF_W-1:0]), $past(pat_lo)} &&
         fmt_ext == $past(pat_hi[PHI_W-1 -: EXT_W])));

    a_r3_high_raises_ext: assert property (@(posedge clk) disable iff (rst)
        (core_range == 2'b01 && !mode_pattern && !mode_off) |=> (fmt_ext == 2'b11));

    a_r4_ext_low_otherwise: assert property (@(posedge clk) disable iff (rst)
        (core_range != 2'b01 && !mode_pattern) |=> (fmt_ext == 2'b00));

    a_r6_lsb_kept: assert property (@(posedge clk) disable iff (rst)
        (core_range[0] == core_range[1] && !mode_pattern && !mode_off) |=>
        (fmt_data[0] == $past(core_code[0])));

    a_r10_markers_follow: assert property (@(posedge clk) disable iff (rst)
        !mode_off |=> (fmt_frame == $past(frame_in) && fmt_dclk == $past(dclk_in)));

endmodule

// File: tb/sim_adc_out_formatter.sv
module sim_adc_out_formatter;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] core_code;
    logic [1:0]  core_range;
    logic        frame_in, dclk_in;
    logic        mode_twos, mode_scramble, mode_pattern, mode_off;
    logic [7:0]  pat_hi;
    logic [5:0]  pat_lo;
    logic [11:0] fmt_data;
    logic [1:0]  fmt_ext;
    logic        fmt_frame, fmt_dclk;
    logic [11:0] rx_data;
    logic        rx_scramble;
    logic [11:0] rx_plain;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    adc_out_formatter u0 (
        .clk(clk), .rst(rst), .core_code(core_code), .core_range(core_range),
        .frame_in(frame_in), .dclk_in(dclk_in), .mode_twos(mode_twos),
        .mode_scramble(mode_scramble), .mode_pattern(mode_pattern), .mode_off(mode_off),
        .pat_hi(pat_hi), .pat_lo(pat_lo), .fmt_data(fmt_data), .fmt_ext(fmt_ext),
        .fmt_frame(fmt_frame), .fmt_dclk(fmt_dclk), .rx_data(rx_data),
        .rx_scramble(rx_scramble), .rx_plain(rx_plain)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Present one sample at a falling edge; results are read at the next falling edge.
    task automatic sample(input logic [11:0] code, input logic [1:0] rng,
                          input logic fr, input logic dc);
        @(negedge clk);
        core_code  = code;
        core_range = rng;
        frame_in   = fr;
        dclk_in    = dc;
        @(negedge clk);
    endtask

    task automatic set_modes(input logic tw, input logic sc, input logic pt, input logic off);
        mode_twos = tw; mode_scramble = sc; mode_pattern = pt; mode_off = off;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        core_code = 12'hABC; core_range = 2'b01; frame_in = 1'b1; dclk_in = 1'b1;
        pat_hi = '0; pat_lo = '0; rx_data = '0; rx_scramble = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 data", {4'h0, fmt_data}, 16'h0000);
        check("R1 ext/frame/dclk", {13'h0, fmt_ext, fmt_frame} | {15'h0, fmt_dclk}, 16'h0000);
        rst = 1'b0;
    endtask

    task automatic t_offset();
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        sample(12'h800, 2'b00, 1'b0, 1'b0);
        check("R2 mid", {fmt_ext, 2'b00, fmt_data}, 16'h0800);
        sample(12'h5A3, 2'b00, 1'b0, 1'b0);
        check("R2 code", {fmt_ext, 2'b00, fmt_data}, 16'h05A3);
    endtask

    task automatic t_twos();
        set_modes(1'b1, 1'b0, 1'b0, 1'b0);
        sample(12'h800, 2'b00, 1'b0, 1'b0);
        check("R5 mid", {4'h0, fmt_data}, 16'h0000);
        sample(12'h7FF, 2'b00, 1'b0, 1'b0);
        check("R5 below mid", {4'h0, fmt_data}, 16'h0FFF);
        sample(12'h801, 2'b00, 1'b0, 1'b0);
        check("R5 above mid", {4'h0, fmt_data}, 16'h0001);
    endtask

    task automatic t_overrange();
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        sample(12'h123, 2'b01, 1'b0, 1'b0);
        check("R3 offset high", {fmt_ext, 2'b00, fmt_data}, 16'hCFFF);
        sample(12'h123, 2'b10, 1'b0, 1'b0);
        check("R4 offset low", {fmt_ext, 2'b00, fmt_data}, 16'h0000);
        set_modes(1'b1, 1'b0, 1'b0, 1'b0);
        sample(12'h123, 2'b01, 1'b0, 1'b0);
        check("R3 twos high", {fmt_ext, 2'b00, fmt_data}, 16'hC7FF);
        sample(12'h123, 2'b10, 1'b0, 1'b0);
        check("R4 twos low", {fmt_ext, 2'b00, fmt_data}, 16'h0800);
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        sample(12'h123, 2'b11, 1'b0, 1'b0);
        check("R11 flag 11", {fmt_ext, 2'b00, fmt_data}, 16'h0123);
    endtask

    task automatic t_scramble();
        set_modes(1'b0, 1'b1, 1'b0, 1'b0);
        sample(12'h5A3, 2'b00, 1'b0, 1'b0);
        check("R6 odd lsb", {4'h0, fmt_data}, 16'h0A5D);
        rx_data = fmt_data; rx_scramble = 1'b1; #1;
        check("R7 decode odd", {4'h0, rx_plain}, 16'h05A3);
        sample(12'h5A2, 2'b00, 1'b0, 1'b0);
        check("R6 even lsb", {4'h0, fmt_data}, 16'h05A2);
        set_modes(1'b1, 1'b1, 1'b0, 1'b0);
        sample(12'h801, 2'b00, 1'b0, 1'b0);
        // two's step gives 001, then bit 0 folds into bits 11..1
        check("R6 after twos", {4'h0, fmt_data}, 16'h0FFF);
        rx_data = fmt_data; rx_scramble = 1'b1; #1;
        check("R7 decode twos", {4'h0, rx_plain}, 16'h0001);
        rx_data = 12'h5A3; rx_scramble = 1'b0; #1;
        check("R7 bypass", {4'h0, rx_plain}, 16'h05A3);
    endtask

    task automatic t_pattern();
        set_modes(1'b1, 1'b1, 1'b1, 1'b0);
        pat_hi = 8'b10_101101; pat_lo = 6'b010011;
        sample(12'h321, 2'b01, 1'b0, 1'b0);
        check("R8 data", {4'h0, fmt_data}, 16'h0B53);
        check("R8 ext", {14'h0, fmt_ext}, 16'h0002);
        pat_hi = 8'b01_000001; pat_lo = 6'b111110;
        sample(12'h000, 2'b10, 1'b0, 1'b0);
        check("R8 new pattern", {fmt_ext, 2'b00, fmt_data}, 16'h407E);
    endtask

    task automatic t_markers();
        set_modes(1'b0, 1'b1, 1'b1, 1'b0);
        sample(12'hFFF, 2'b00, 1'b1, 1'b0);
        check("R10 frame", {14'h0, fmt_frame, fmt_dclk}, 16'h0002);
        sample(12'hFFF, 2'b00, 1'b0, 1'b1);
        check("R10 dclk", {14'h0, fmt_frame, fmt_dclk}, 16'h0001);
    endtask

    task automatic t_disable();
        set_modes(1'b1, 1'b1, 1'b1, 1'b1);
        pat_hi = 8'hFF; pat_lo = 6'h3F;
        sample(12'hFFF, 2'b01, 1'b1, 1'b1);
        check("R9 all low", {fmt_ext, fmt_frame, fmt_dclk, fmt_data}, 16'h0000);
        set_modes(1'b0, 1'b0, 1'b0, 1'b0);
        sample(12'h0F0, 2'b00, 1'b1, 1'b1);
        check("R9 re-enable", {fmt_ext, fmt_frame, fmt_dclk, fmt_data}, 16'h30F0);
    endtask

    initial begin
        t_reset();
        t_offset();
        t_twos();
        t_overrange();
        t_scramble();
        t_pattern();
        t_markers();
        t_disable();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule